// File: doc/BRIEF.md
# Reaction LED Game Controller

This block runs a reflex game on five LEDs and five matching push buttons. Each round lights exactly one LED, picked from a 4-bit pseudo-random sequence, for a programmable number of slow ticks. A player who presses the button under the lit LED before it goes dark earns one point. The points are kept as a single BCD digit for an external seven-segment driver. After a fixed number of rounds the block raises a game-over flag and waits for a new start request.

All timing runs on the system clock. A prescaler produces a one-cycle tick, and the round timer, the dark gap between rounds and the random source all advance on that tick. The `on_ticks_i` input sets the difficulty. At the default tick of 0.1 s at 50 MHz, values of 10 to 20 give one to two seconds. Button inputs are expected to be debounced and synchronised already.

Top module: `reflex_game_top`

## Requirements
- R1: While a round is lit, exactly one bit of `led_o` is high, and that bit does not change until the round ends. At all other times `led_o` is zero. Bit i of `led_o` drives LED i, and LED i matches bit i of `btn_i`.
- R2: The random source is a 4-bit shift register. Reset loads it with binary 1000. At each round launch it shifts left once, taking bit 3 XOR bit 2 into bit 0. The lit LED index is the new value modulo 5. Starting a new game does not reload the register; only reset does.
- R3: A round stays lit for exactly `on_ticks_i` × PRESCALE clock cycles. A value of 0 is treated as 1.
- R4: If the button of the lit LED is high in any cycle of the lit period, the score rises by one. A round scores at most one point, however many times the button is pressed.
- R5: A press on any other button, or a press while all LEDs are dark, leaves the score unchanged. Neither kind of press shortens the round.
- R6: Between consecutive rounds all LEDs stay dark for exactly GAP_TICKS × PRESCALE cycles.
- R7: `round_o` rises by one at each launch and counts 1 to NUM_ROUNDS (9). When the last round ends, `game_over_o` rises in the same cycle the LED goes dark. It stays high with all LEDs dark until a start request arrives.
- R8: A high `start_i` while idle or game-over clears the score and the round count, clears `game_over_o` and begins a game. A high `start_i` during a game is ignored.
- R9: After reset, `led_o`, `score_o`, `round_o` and `game_over_o` are all zero.
- R10: `score_o` is a BCD digit in the range 0 to 9, and a perfect game reads 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start or replay request |
| btn_i | input | 5 | Debounced button levels, bit i under LED i |
| on_ticks_i | input | 8 | Lit time of each round, in prescaler ticks |
| led_o | output | 5 | LED drives, at most one high |
| score_o | output | 4 | BCD score digit |
| round_o | output | 4 | Current round number, 0 before the first launch |
| game_over_o | output | 1 | High after the last round until the next start |

## Verification
The bench keeps its own model of the shift register and the modulo mapping, so it knows which LED must light in every round. A wrong tap or a missing reload on reset would light the wrong LED. Every lit period and every inter-round gap is measured in cycles. An off-by-one in the tick compare, or a timer that stops early on a press, therefore shows up as a length error. Double presses, presses on a neighbouring button and presses just after the LED goes dark each target a scoring flaw. A design without a per-round hit latch would score twice, and one that does not test the button index or the lit state would score on a wrong or late press. A start pulse in mid-game and a reset in mid-game check that a game cannot restart by accident and that the random sequence starts again from its seed.

// File: rtl/game_pkg.sv
// Package: shared types for the reaction game controller.
// Assumes nothing beyond the standard: holds only the sequencer state encoding.
package game_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_LIT  = 2'd2,
        ST_DONE = 2'd3
    } game_state_t;

endpackage

// File: rtl/tick_prescaler.sv
// Module: free-running divider that emits a one-cycle tick every DIV cycles.
// Assumes DIV >= 2. The tick is an enable on the system clock, never a clock itself.
module tick_prescaler #(
    parameter int DIV = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    // Tick on the last count of each period.
    assign tick_o = (cnt_q == CW'(DIV - 1));

    // Count cycles and wrap to zero on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/lfsr_picker.sv
// Module: shift-register random source with a modulo map onto LED indices.
// Assumes W >= 2. The feedback is the XOR of the two top bits, shifted in at bit 0.
// idx_o is the index the register will hold after the next step, so a caller
// that latches idx_o on the step cycle gets the value of the new state.
module lfsr_picker #(
    parameter int           W        = 4,
    parameter logic [W-1:0] SEED     = 4'b1000,
    parameter int           NUM_LEDS = 5,
    parameter int           IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [IDX_W-1:0] idx_o
);

    logic [W-1:0] lfsr_q;
    logic [W-1:0] lfsr_d;

    // Next state: shift left, feedback into the low bit.
    assign lfsr_d = {lfsr_q[W-2:0], lfsr_q[W-1] ^ lfsr_q[W-2]};

    // Reload the seed on reset; advance only when a round launches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else if (step_i) begin
            lfsr_q <= lfsr_d;
        end
    end

    // Fold the next state into the range 0 .. NUM_LEDS-1.
    always_comb begin
        idx_o = IDX_W'(32'(lfsr_d) % NUM_LEDS);
    end

endmodule

// File: rtl/round_sequencer.sv
// Module: game state machine with gap timer, lit timer, hit latch, score and round count.
// Assumes tick_i is a one-cycle enable and btn_i is already debounced and synchronous.
// Start requests are honoured only while idle or after game over.
module round_sequencer
    import game_pkg::*;
#(
    parameter int NUM_LEDS   = 5,
    parameter int NUM_ROUNDS = 9,
    parameter int GAP_TICKS  = 3,
    parameter int ON_W       = 8,
    parameter int IDX_W      = 3,
    parameter int RND_W      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                start_i,
    input  logic [NUM_LEDS-1:0] btn_i,
    input  logic [ON_W-1:0]     on_ticks_i,
    input  logic [IDX_W-1:0]    idx_i,
    output logic                step_o,
    output logic                lit_o,
    output logic [IDX_W-1:0]    target_o,
    output logic [3:0]          score_o,
    output logic [RND_W-1:0]    round_o,
    output logic                game_over_o
);

    localparam int             GAP_W    = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_TICKS - 1);
    localparam logic [3:0]     SCORE_MAX = 4'd9;

    game_state_t      state_q;
    logic [GAP_W-1:0] gap_cnt_q;
    logic [ON_W-1:0]  on_cnt_q;
    logic [ON_W-1:0]  on_last;
    logic [IDX_W-1:0] target_q;
    logic             hit_q;
    logic [3:0]       score_q;
    logic [RND_W-1:0] round_q;
    logic             launch;
    logic             lit_end;
    logic             new_game;
    logic             score_hit;

    // Last tick index of the lit period; a zero setting acts as one tick.
    assign on_last   = (on_ticks_i == '0) ? '0 : on_ticks_i - ON_W'(1);

    // Event decodes shared by the processes below.
    assign new_game  = ((state_q == ST_IDLE) || (state_q == ST_DONE)) && start_i;
    assign launch    = (state_q == ST_GAP) && tick_i && (gap_cnt_q == GAP_LAST);
    assign lit_end   = (state_q == ST_LIT) && tick_i && (on_cnt_q == on_last);
    assign score_hit = (state_q == ST_LIT) && !hit_q && btn_i[target_q];

    // State transitions between idle, gap, lit and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: if (new_game) state_q <= ST_GAP;
                ST_GAP:           if (launch)   state_q <= ST_LIT;
                ST_LIT: begin
                    if (lit_end) begin
                        state_q <= (round_q == RND_W'(NUM_ROUNDS)) ? ST_DONE : ST_GAP;
                    end
                end
                default:          state_q <= ST_IDLE;
            endcase
        end
    end

    // Gap timer: counts ticks of darkness before each launch.
    always_ff @(posedge clk) begin
        if (!rst_n || new_game || lit_end || launch) begin
            gap_cnt_q <= '0;
        end else if ((state_q == ST_GAP) && tick_i) begin
            gap_cnt_q <= gap_cnt_q + GAP_W'(1);
        end
    end

    // Lit timer: counts ticks while the target LED is on.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            on_cnt_q <= '0;
        end else if ((state_q == ST_LIT) && tick_i && !lit_end) begin
            on_cnt_q <= on_cnt_q + ON_W'(1);
        end
    end

    // Target capture at launch from the random source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
        end else if (launch) begin
            target_q <= idx_i;
        end
    end

    // Hit latch: allows one point per round.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            hit_q <= 1'b0;
        end else if (score_hit) begin
            hit_q <= 1'b1;
        end
    end

    // BCD score: clears on a new game, saturates at nine.
    always_ff @(posedge clk) begin
        if (!rst_n || new_game) begin
            score_q <= '0;
        end else if (score_hit && (score_q != SCORE_MAX)) begin
            score_q <= score_q + 4'd1;
        end
    end

    // Round counter: clears on a new game, steps at each launch.
    always_ff @(posedge clk) begin
        if (!rst_n || new_game) begin
            round_q <= '0;
        end else if (launch) begin
            round_q <= round_q + RND_W'(1);
        end
    end

    assign step_o      = launch;
    assign lit_o       = (state_q == ST_LIT);
    assign target_o    = target_q;
    assign score_o     = score_q;
    assign round_o     = round_q;
    assign game_over_o = (state_q == ST_DONE);

endmodule

// File: rtl/reflex_game_top.sv
// Module: top of the reaction LED game; ties the prescaler, random source and
// sequencer together and decodes the target index into one-hot LED drives.
// Assumes debounced buttons and a display driver outside the block.
module reflex_game_top #(
    parameter int  NUM_LEDS   = 5,
    parameter int  NUM_ROUNDS = 9,
    parameter int  PRESCALE   = 5_000_000,
    parameter int  GAP_TICKS  = 3,
    parameter int  ON_W       = 8,
    parameter int  LFSR_W     = 4,
    localparam int RND_W      = $clog2(NUM_ROUNDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [NUM_LEDS-1:0] btn_i,
    input  logic [ON_W-1:0]     on_ticks_i,
    output logic [NUM_LEDS-1:0] led_o,
    output logic [3:0]          score_o,
    output logic [RND_W-1:0]    round_o,
    output logic                game_over_o
);

    localparam int IDX_W = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1;

    logic             tick;
    logic             step;
    logic             lit;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] target;

    tick_prescaler #(
        .DIV (PRESCALE)
    ) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    lfsr_picker #(
        .W        (LFSR_W),
        .SEED     (LFSR_W'(4'b1000)),
        .NUM_LEDS (NUM_LEDS),
        .IDX_W    (IDX_W)
    ) u_picker (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .idx_o  (pick_idx)
    );

    round_sequencer #(
        .NUM_LEDS   (NUM_LEDS),
        .NUM_ROUNDS (NUM_ROUNDS),
        .GAP_TICKS  (GAP_TICKS),
        .ON_W       (ON_W),
        .IDX_W      (IDX_W),
        .RND_W      (RND_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .start_i     (start_i),
        .btn_i       (btn_i),
        .on_ticks_i  (on_ticks_i),
        .idx_i       (pick_idx),
        .step_o      (step),
        .lit_o       (lit),
        .target_o    (target),
        .score_o     (score_o),
        .round_o     (round_o),
        .game_over_o (game_over_o)
    );

    // One-hot LED decode, one comparator per LED.
    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
        assign led_o[i] = lit && (target == IDX_W'(i));
    end

endmodule

// File: rtl/game_checker.sv
// Module: property checker for the reaction game, attached to the top by bind.
// Assumes the same parameters as the top; observes ports only.
module game_checker #(
    parameter int NUM_LEDS   = 5,
    parameter int NUM_ROUNDS = 9,
    parameter int RND_W      = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_LEDS-1:0] btn_i,
    input logic [NUM_LEDS-1:0] led_o,
    input logic [3:0]          score_o,
    input logic [RND_W-1:0]    round_o,
    input logic                game_over_o
);

    // R1
    led_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(led_o));

    // R1
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((led_o != '0) && ($past(led_o) != '0)) |-> (led_o == $past(led_o)));

    // R4
    score_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((score_o != $past(score_o)) && (score_o != 4'd0))
        |-> ((score_o == $past(score_o) + 4'd1) && (($past(led_o) & $past(btn_i)) != '0)));

    // R7
    over_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        game_over_o |-> (led_o == '0));

    // R7
    round_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        round_o <= RND_W'(NUM_ROUNDS));

    // R10
    score_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        score_o <= 4'd9);

endmodule

bind reflex_game_top game_checker #(
    .NUM_LEDS   (NUM_LEDS),
    .NUM_ROUNDS (NUM_ROUNDS),
    .RND_W      (RND_W)
) u_game_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .btn_i       (btn_i),
    .led_o       (led_o),
    .score_o     (score_o),
    .round_o     (round_o),
    .game_over_o (game_over_o)
);

// File: tb/tb_reflex_game_top.sv
// Bench: a table of per-round player actions walked by one loop, then directed
// tests for replay, mid-game start, perfect score and mid-game reset.
module tb_reflex_game_top;

    localparam int PS  = 4;
    localparam int GAP = 2;

    // Player action per round of the first game:
    // 0 none, 1 correct press, 2 neighbour press, 3 correct press twice, 4 late press
    localparam int ACT [9] = '{1, 0, 2, 3, 1, 4, 1, 3, 1};

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [4:0] btn_i;
    logic [7:0] on_ticks_i;
    logic [4:0] led_o;
    logic [3:0] score_o;
    logic [3:0] round_o;
    logic       game_over_o;

    int         checks = 0;
    int         fails = 0;
    int         exp_score = 0;
    int         dark_carry = 0;
    logic [3:0] lfsr_m;

    always #10 clk = ~clk;

    reflex_game_top #(
        .PRESCALE  (PS),
        .GAP_TICKS (GAP)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .btn_i       (btn_i),
        .on_ticks_i  (on_ticks_i),
        .led_o       (led_o),
        .score_o     (score_o),
        .round_o     (round_o),
        .game_over_o (game_over_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] lfsr_next(input logic [3:0] v);
        return {v[2:0], v[3] ^ v[2]};
    endfunction

    function automatic logic [4:0] drive(input int act, input int idx, input int c);
        logic [4:0] b = '0;
        if ((act == 1 || act == 3) && (c == 2 || c == 3)) b = 5'(1 << idx);
        if (act == 3 && (c == 6 || c == 7)) b = 5'(1 << idx);
        if (act == 2 && (c == 2 || c == 3)) b = 5'(1 << ((idx + 1) % 5));
        return b;
    endfunction

    // Play one round, entered at a negedge in the dark phase.
    task automatic play_round(input int r, input int act, input int on, input bit chk_gap);
        int dark = dark_carry;
        int c = 1;
        int idx;
        logic [4:0] exp_led;
        while (led_o == '0) begin
            dark++;
            @(negedge clk);
        end
        if (chk_gap) check(dark == GAP * PS, "R6 gap length", dark, GAP * PS);
        lfsr_m  = lfsr_next(lfsr_m);
        idx     = int'(lfsr_m) % 5;
        exp_led = 5'(1 << idx);
        check(led_o == exp_led, "R2 lit LED", int'(led_o), int'(exp_led));
        check($countones(led_o) == 1, "R1 single LED", $countones(led_o), 1);
        check(int'(round_o) == r, "R7 round count", int'(round_o), r);
        while (led_o != '0) begin
            btn_i   = drive(act, idx, c);
            start_i = (r == 3 && c == 5);
            @(negedge clk);
            if (led_o != '0) c++;
        end
        btn_i   = '0;
        start_i = 1'b0;
        check(c == on * PS, (act == 2) ? "R5 lit length after wrong press" : "R3 lit length", c, on * PS);
        if (act == 1 || act == 3) exp_score++;
        check(int'(score_o) == exp_score, (act == 3) ? "R4 one point per round" : "R4 score", int'(score_o), exp_score);
        if (r == 3) check(round_o == 4'd3, "R8 start ignored mid-game", int'(round_o), 3);
        dark_carry = 0;
        if (act == 4) begin
            btn_i = exp_led;
            @(negedge clk);
            @(negedge clk);
            btn_i = '0;
            dark_carry = 2;
            check(int'(score_o) == exp_score, "R5 late press", int'(score_o), exp_score);
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        bit stayed_dark;
        rst_n      = 1'b0;
        start_i    = 1'b0;
        btn_i      = '0;
        on_ticks_i = 8'd5;
        lfsr_m     = 4'b1000;
        repeat (3) @(negedge clk);
        check({led_o, score_o, round_o, game_over_o} == '0, "R9 reset outputs",
              int'({led_o, score_o, round_o, game_over_o}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(led_o == '0 && !game_over_o, "R9 idle after reset", int'(led_o), 0);

        // Game 1: table-driven actions
        pulse_start();
        check(score_o == 4'd0 && round_o == 4'd0, "R8 start clears", int'(score_o), 0);
        exp_score = 0;
        for (int r = 1; r <= 9; r++) begin
            play_round(r, ACT[r-1], 5, r > 1);
        end
        check(game_over_o == 1'b1, "R7 game over", int'(game_over_o), 1);
        check(round_o == 4'd9, "R7 final round", int'(round_o), 9);
        check(score_o == 4'd6, "R4 final score", int'(score_o), 6);
        stayed_dark = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (led_o != '0 || !game_over_o) stayed_dark = 1'b0;
        end
        check(stayed_dark, "R7 idle while game over", int'(stayed_dark), 1);

        // Game 2: replay with shorter on-time, every round hit
        on_ticks_i = 8'd3;
        pulse_start();
        check(score_o == 4'd0 && round_o == 4'd0 && !game_over_o, "R8 replay clears",
              int'(score_o) + int'(round_o) + int'(game_over_o), 0);
        exp_score  = 0;
        dark_carry = 0;
        for (int r = 1; r <= 9; r++) begin
            play_round(r, 1, 3, r > 1);
        end
        check(score_o == 4'd9, "R10 perfect score", int'(score_o), 9);

        // Game 3: reset in mid-game reloads the seed
        pulse_start();
        while (led_o == '0) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check({led_o, score_o, round_o, game_over_o} == '0, "R9 mid-game reset",
              int'({led_o, score_o, round_o, game_over_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        pulse_start();
        while (led_o == '0) @(negedge clk);
        check(led_o == 5'b00010, "R2 seed reloaded by reset", int'(led_o), 2);

        finish_run();
    end

endmodule